// File: doc/BRIEF.md
# Serial Port Byte Mover Channel

This block is one channel of a direct memory access engine that sits next to a serial transceiver. It moves one byte at a time between a memory area and the transceiver's data register. The transceiver's status flags pace every move: in the transmit direction a byte is fetched from memory whenever the transmit buffer is empty, and in the receive direction a byte is taken from the data register whenever the receive buffer is full. A transfer is two single-beat bus accesses, a read from the source followed by a write to the destination.

Software programs the peripheral address, the memory start address, the byte count, the direction, a priority value and two interrupt enables, then sets the channel enable. The peripheral address stays fixed. The memory address advances after each byte. The channel raises a half-way flag and a completion flag, and at completion it switches itself off. The priority value is only stored and presented on an output for an arbiter outside this block.

Top module: `uart_dma_chan`

## Requirements
- R1: After reset the channel is disabled, both flags are clear, the remaining count is zero and no bus access is requested.
- R2: With control bit 1 set (transmit), each transfer reads the byte at the current memory address (`bus_we_o`=0) and then writes that byte to the peripheral address (`bus_we_o`=1).
- R3: With control bit 1 clear (receive), each transfer reads the peripheral address and then writes that byte to the current memory address.
- R4: The direction picks the request. Transmit uses `tx_empty_i` AND `tx_dma_en_i`. Receive uses `rx_full_i` AND `rx_dma_en_i`. The request of the other direction, and a request whose enable is low, moves no byte.
- R5: After a transfer completes, no new transfer starts until the selected request has been seen low at least once.
- R6: The memory address increments by one after each completed byte. The peripheral address never changes during a transfer.
- R7: The remaining count drops by one per completed byte. When it reaches zero, the completion flag sets, the channel clears its own enable, and later requests move no byte.
- R8: The half flag sets on the byte that brings the remaining count to the programmed count divided by two, rounded down.
- R9: Both flags stay set until a configuration write to offset 4 with a 1 in bit 0 (half) or bit 1 (completion) clears them.
- R10: `irq_half_o` is the half flag ANDed with control bit 4. `irq_done_o` is the completion flag ANDed with control bit 5.
- R11: Register offsets are 0 for the peripheral address, 1 for the memory address, 2 for the count and 3 for control (bit 0 enable, bits 3:2 priority). Setting the enable while the count is zero leaves the channel disabled. Writes to offsets 0 to 2 are ignored while the channel is enabled.
- R12: A bus request holds its address, write strobe and write data unchanged until `bus_ack_i` is seen. Bytes arrive intact regardless of acknowledge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register offset |
| cfg_wdata_i | input | DW | Configuration write data |
| tx_empty_i | input | 1 | Transceiver transmit buffer empty |
| tx_dma_en_i | input | 1 | Transceiver enables transmit requests |
| rx_full_i | input | 1 | Transceiver receive buffer full |
| rx_dma_en_i | input | 1 | Transceiver enables receive requests |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | AW | Bus byte address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access complete |
| chan_en_o | output | 1 | Channel enable state |
| prio_o | output | 2 | Stored priority |
| mem_addr_o | output | AW | Current memory address |
| remaining_o | output | CW | Bytes left to move |
| half_flag_o | output | 1 | Half-way flag |
| done_flag_o | output | 1 | Completion flag |
| irq_half_o | output | 1 | Half-way interrupt |
| irq_done_o | output | 1 | Completion interrupt |

## Verification
The assertions watch the bus handshake on every cycle: held address, strobe and data while unacknowledged, and a return to idle after each write. They also check that no access starts while the channel is off, that the count only ever steps down by one outside configuration writes, that the channel is off when completion is flagged, and that interrupts never appear without their flag. The byte values and address sequence in each direction, the re-arm rule on a request held high, the independence of the two request paths and the ignored writes while enabled can only be shown by the bench scenarios, which compare the transceiver and memory models against computed contents.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [1:0] {X_IDLE, X_RD, X_WR} xfer_st_e;

  localparam logic [2:0] REG_PADDR = 3'd0;
  localparam logic [2:0] REG_MADDR = 3'd1;
  localparam logic [2:0] REG_CNT   = 3'd2;
  localparam logic [2:0] REG_CTRL  = 3'd3;
  localparam logic [2:0] REG_CLR   = 3'd4;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_TX  = 1;
  localparam int CTRL_PRL = 2;
  localparam int CTRL_HIE = 4;
  localparam int CTRL_CIE = 5;
endpackage

// File: rtl/udc_regs.sv
module udc_regs
  import udc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int PW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          xfer_done_i,
  output logic          en_o,
  output logic          dir_tx_o,
  output logic [PW-1:0] prio_o,
  output logic          hie_o,
  output logic          cie_o,
  output logic [AW-1:0] paddr_o,
  output logic [AW-1:0] maddr_o,
  output logic [CW-1:0] rem_o,
  output logic          half_o,
  output logic          done_o
);
  logic          en_q, tx_q, hie_q, cie_q, half_q, done_q;
  logic [PW-1:0] prio_q;
  logic [AW-1:0] paddr_q, maddr_q;
  logic [CW-1:0] rem_q, thr_q;
  logic [CW-1:0] rem_next;

  assign rem_next = rem_q - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      tx_q    <= 1'b0;
      hie_q   <= 1'b0;
      cie_q   <= 1'b0;
      half_q  <= 1'b0;
      done_q  <= 1'b0;
      prio_q  <= '0;
      paddr_q <= '0;
      maddr_q <= '0;
      rem_q   <= '0;
      thr_q   <= '0;
    end else begin
      if (cfg_we_i) begin
        unique case (cfg_addr_i)
          REG_PADDR: if (!en_q) paddr_q <= cfg_wdata_i[AW-1:0];
          REG_MADDR: if (!en_q) maddr_q <= cfg_wdata_i[AW-1:0];
          REG_CNT: if (!en_q) begin
            rem_q <= cfg_wdata_i[CW-1:0];
            thr_q <= cfg_wdata_i[CW-1:0] >> 1;
          end
          REG_CTRL: begin
            en_q   <= cfg_wdata_i[CTRL_EN] && (rem_q != '0);
            tx_q   <= cfg_wdata_i[CTRL_TX];
            prio_q <= cfg_wdata_i[CTRL_PRL +: PW];
            hie_q  <= cfg_wdata_i[CTRL_HIE];
            cie_q  <= cfg_wdata_i[CTRL_CIE];
          end
          REG_CLR: begin
            if (cfg_wdata_i[0]) half_q <= 1'b0;
            if (cfg_wdata_i[1]) done_q <= 1'b0;
          end
          default: ;
        endcase
      end
      // completion wins over a same-cycle clear
      if (xfer_done_i) begin
        rem_q   <= rem_next;
        maddr_q <= maddr_q + AW'(1);
        if (rem_next == thr_q) half_q <= 1'b1;
        if (rem_next == '0) begin
          en_q   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign en_o     = en_q;
  assign dir_tx_o = tx_q;
  assign prio_o   = prio_q;
  assign hie_o    = hie_q;
  assign cie_o    = cie_q;
  assign paddr_o  = paddr_q;
  assign maddr_o  = maddr_q;
  assign rem_o    = rem_q;
  assign half_o   = half_q;
  assign done_o   = done_q;
endmodule

// File: rtl/udc_req.sv
module udc_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dir_tx_i,
  input  logic idle_i,
  input  logic xfer_done_i,
  input  logic tx_empty_i,
  input  logic tx_dma_en_i,
  input  logic rx_full_i,
  input  logic rx_dma_en_i,
  output logic start_o
);
  logic sel_req, armed_q;

  assign sel_req = dir_tx_i ? (tx_empty_i & tx_dma_en_i) : (rx_full_i & rx_dma_en_i);

  // re-arm only after the serviced request has been seen low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_q <= 1'b1;
    else if (xfer_done_i) armed_q <= !sel_req;
    else if (!sel_req)    armed_q <= 1'b1;
  end

  assign start_o = en_i && idle_i && sel_req && armed_q;
endmodule

// File: rtl/udc_xfer.sv
module udc_xfer
  import udc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dir_tx_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [AW-1:0] maddr_i,
  input  logic          bus_ack_i,
  input  logic [7:0]    bus_rdata_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  output logic          idle_o,
  output logic          done_o
);
  xfer_st_e st_q;
  logic     tx_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= X_IDLE;
      tx_q   <= 1'b0;
      byte_q <= '0;
    end else begin
      unique case (st_q)
        X_IDLE: if (start_i) begin
          st_q <= X_RD;
          tx_q <= dir_tx_i;
        end
        X_RD: if (bus_ack_i) begin
          byte_q <= bus_rdata_i;
          st_q   <= X_WR;
        end
        X_WR: if (bus_ack_i) st_q <= X_IDLE;
        default: st_q <= X_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req_o  = (st_q != X_IDLE);
    bus_we_o   = (st_q == X_WR);
    bus_addr_o = '0;
    if (st_q == X_RD) bus_addr_o = tx_q ? maddr_i : paddr_i;
    else if (st_q == X_WR) bus_addr_o = tx_q ? paddr_i : maddr_i;
  end

  assign bus_wdata_o = byte_q;
  assign idle_o      = (st_q == X_IDLE);
  assign done_o      = (st_q == X_WR) && bus_ack_i;
endmodule

// File: rtl/uart_dma_chan.sv
module uart_dma_chan
  import udc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int PW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          tx_empty_i,
  input  logic          tx_dma_en_i,
  input  logic          rx_full_i,
  input  logic          rx_dma_en_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  input  logic [7:0]    bus_rdata_i,
  input  logic          bus_ack_i,
  output logic          chan_en_o,
  output logic [PW-1:0] prio_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [CW-1:0] remaining_o,
  output logic          half_flag_o,
  output logic          done_flag_o,
  output logic          irq_half_o,
  output logic          irq_done_o
);
  logic          en, dir_tx, hie, cie, half, done, start, idle, xfer_done;
  logic [AW-1:0] paddr, maddr;

  udc_regs #(.DW(DW), .AW(AW), .CW(CW), .PW(PW)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .xfer_done_i(xfer_done),
    .en_o(en), .dir_tx_o(dir_tx), .prio_o(prio_o), .hie_o(hie), .cie_o(cie),
    .paddr_o(paddr), .maddr_o(maddr), .rem_o(remaining_o),
    .half_o(half), .done_o(done)
  );

  udc_req u_req (
    .clk_i, .rst_ni, .en_i(en), .dir_tx_i(dir_tx), .idle_i(idle),
    .xfer_done_i(xfer_done), .tx_empty_i, .tx_dma_en_i, .rx_full_i,
    .rx_dma_en_i, .start_o(start)
  );

  udc_xfer #(.AW(AW)) u_xfer (
    .clk_i, .rst_ni, .start_i(start), .dir_tx_i(dir_tx), .paddr_i(paddr),
    .maddr_i(maddr), .bus_ack_i, .bus_rdata_i, .bus_req_o, .bus_we_o,
    .bus_addr_o, .bus_wdata_o, .idle_o(idle), .done_o(xfer_done)
  );

  assign chan_en_o   = en;
  assign mem_addr_o  = maddr;
  assign half_flag_o = half;
  assign done_flag_o = done;
  assign irq_half_o  = half & hie;
  assign irq_done_o  = done & cie;
endmodule

// File: rtl/udc_chk.sv
module udc_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          bus_ack_i,
  input logic [AW-1:0] bus_addr_o,
  input logic [7:0]    bus_wdata_o,
  input logic          chan_en_o,
  input logic [CW-1:0] remaining_o,
  input logic          half_flag_o,
  input logic          done_flag_o,
  input logic          irq_half_o,
  input logic          irq_done_o
);
  p_bus_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
                                $stable(bus_we_o) && $stable(bus_wdata_o));

  p_write_ends_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_ack_i |=> !bus_req_o);

  p_start_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(chan_en_o));

  p_auto_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_flag_o) |-> !chan_en_o);

  p_count_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(remaining_o) && !$past(cfg_we_i) |-> remaining_o == $past(remaining_o) - CW'(1));

  p_irq_half_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_half_o |-> half_flag_o);

  p_irq_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |-> done_flag_o);
endmodule

bind uart_dma_chan udc_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .bus_req_o(bus_req_o),
  .bus_we_o(bus_we_o), .bus_ack_i(bus_ack_i), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .chan_en_o(chan_en_o), .remaining_o(remaining_o),
  .half_flag_o(half_flag_o), .done_flag_o(done_flag_o),
  .irq_half_o(irq_half_o), .irq_done_o(irq_done_o)
);

// File: tb/uart_dma_chan_tb.sv
module uart_dma_chan_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] PA = 32'h100;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        tx_empty, rx_full;
  logic        tx_dma_en = 1, rx_dma_en = 1;
  logic        bus_req, bus_we, bus_ack;
  logic [31:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        chan_en, half_f, done_f, irq_h, irq_d;
  logic [1:0]  prio;
  logic [31:0] mem_addr;
  logic [15:0] remaining;

  logic        tx_kick = 0, tx_drop = 0, rx_kick = 0, sticky = 0;
  logic [7:0]  rx_byte = 0;
  int          ack_wait = 0, wcnt;
  logic [7:0]  tx_log [16];
  int          tx_n;
  logic [7:0]  mem [256];
  int          total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_dma_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .tx_empty_i(tx_empty), .tx_dma_en_i(tx_dma_en),
    .rx_full_i(rx_full), .rx_dma_en_i(rx_dma_en), .bus_req_o(bus_req),
    .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack), .chan_en_o(chan_en),
    .prio_o(prio), .mem_addr_o(mem_addr), .remaining_o(remaining),
    .half_flag_o(half_f), .done_flag_o(done_f), .irq_half_o(irq_h),
    .irq_done_o(irq_d)
  );

  // memory reads return addr ^ A5, peripheral reads return rx_byte
  assign bus_rdata = (bus_addr == PA) ? rx_byte : (bus_addr[7:0] ^ 8'hA5);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= 0; wcnt <= 0; tx_empty <= 0; rx_full <= 0; tx_n <= 0;
    end else begin
      if (!bus_req || bus_ack) begin bus_ack <= 0; wcnt <= 0; end
      else if (wcnt >= ack_wait) bus_ack <= 1;
      else wcnt <= wcnt + 1;
      if (bus_req && bus_ack && bus_we) begin
        if (bus_addr == PA) begin tx_log[tx_n[3:0]] <= bus_wdata; tx_n <= tx_n + 1; end
        else mem[bus_addr[7:0]] <= bus_wdata;
      end
      if (bus_req && bus_ack && bus_we && bus_addr == PA && !sticky) tx_empty <= 0;
      else if (tx_drop) tx_empty <= 0;
      else if (tx_kick) tx_empty <= 1;
      if (bus_req && bus_ack && !bus_we && bus_addr == PA && !sticky) rx_full <= 0;
      else if (rx_kick) rx_full <= 1;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick_tx();
    @(negedge clk); tx_kick = 1; @(negedge clk); tx_kick = 0; wait_cyc(20);
  endtask

  task automatic kick_rx(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_kick = 1; @(negedge clk); rx_kick = 0; wait_cyc(30);
  endtask

  task automatic t_reset();
    chk("R1 en", chan_en, 0);
    chk("R1 req", bus_req, 0);
    chk("R1 flags", {half_f, done_f}, 0);
    chk("R1 remaining", remaining, 0);
  endtask

  task automatic t_cfg();
    wr(3'd3, 32'h1);
    chk("R11 en with zero count", chan_en, 0);
    wr(3'd0, PA); wr(3'd1, 32'h80); wr(3'd2, 2);
    wr(3'd3, 32'h9);  // enable, receive, prio 2
    chk("R11 enabled", chan_en, 1);
    chk("R11 prio", prio, 2);
    wr(3'd1, 32'h90); wr(3'd2, 7);
    chk("R11 maddr write ignored", mem_addr, 32'h80);
    chk("R11 count write ignored", remaining, 2);
    wr(3'd3, 32'h0);
    chk("R11 disabled", chan_en, 0);
  endtask

  task automatic t_tx();
    wr(3'd1, 32'h10); wr(3'd2, 4);
    wr(3'd3, 32'h33);  // en, tx, hie, cie
    for (int i = 0; i < 4; i++) begin
      kick_tx();
      chk("R2 byte", tx_log[i], (8'h10 + i[7:0]) ^ 8'hA5);
      chk("R7 remaining", remaining, 3 - i);
      chk("R8 half", half_f, (i >= 1) ? 1 : 0);
    end
    chk("R2 count", tx_n, 4);
    chk("R6 mem addr", mem_addr, 32'h14);
    chk("R7 done", done_f, 1);
    chk("R7 auto off", chan_en, 0);
    chk("R10 irq", {irq_h, irq_d}, 2'b11);
    kick_tx();
    chk("R7 ignored after end", tx_n, 4);
    wr(3'd4, 32'h1);
    chk("R9 half cleared done kept", {half_f, done_f}, 2'b01);
    wr(3'd4, 32'h2);
    chk("R9 done cleared", done_f, 0);
  endtask

  task automatic t_rx();
    tx_drop = 1; @(negedge clk); tx_drop = 0;
    ack_wait = 3;
    wr(3'd1, 32'h40); wr(3'd2, 3);
    wr(3'd3, 32'h1);  // en, receive, no irq
    rx_dma_en = 0;
    kick_rx(8'h5A);
    chk("R4 gated by rx enable", remaining, 3);
    kick_tx();
    chk("R4 tx request ignored", tx_n, 4);
    rx_dma_en = 1; wait_cyc(30);
    chk("R3 byte0", mem[8'h40], 8'h5A);
    kick_rx(8'h5B);
    chk("R3 byte1", mem[8'h41], 8'h5B);
    chk("R8 half at 1 of 3", half_f, 1);
    chk("R10 half masked", irq_h, 0);
    kick_rx(8'h5C);
    chk("R12 byte2 slow ack", mem[8'h42], 8'h5C);
    chk("R6 mem addr rx", mem_addr, 32'h43);
    chk("R10 done masked", {done_f, irq_d}, 2'b10);
    ack_wait = 0;
    wr(3'd4, 32'h3);
  endtask

  task automatic t_hold();
    tx_drop = 1; @(negedge clk); tx_drop = 0;
    sticky = 1;
    wr(3'd1, 32'h20); wr(3'd2, 3);
    wr(3'd3, 32'h3);
    kick_tx();
    chk("R5 one byte per request", tx_n, 5);
    chk("R5 remaining", remaining, 2);
    tx_drop = 1; @(negedge clk); tx_drop = 0;
    kick_tx();
    chk("R5 rearmed", tx_n, 6);
    chk("R6 second byte", tx_log[5], 8'h21 ^ 8'hA5);
    sticky = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1;
    wait_cyc(2);
    t_cfg();
    t_tx();
    t_rx();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule